// File: doc/BRIEF.md
# Accumulator Adjust and Word Add Unit

This purely combinational unit serves an 8-bit processor datapath. It computes the result of the single-operand accumulator instructions and of the register-pair addition. The accumulator operations are the four one-bit rotates, ones' complement, carry set, carry complement and the decimal correction that follows BCD addition. In the same evaluation the unit also forms the word sum of two register-pair operands. Each operation rewrites only the flag bits it defines. Every other bit of the incoming flag byte passes to the output unchanged. The surrounding core handles instruction decode and register storage. It drives the operation code and the current register values, then writes back whichever outputs the instruction needs.

The word width is a parameter. The half-carry tap and the two copied sum bits follow from it. The flag byte layout is fixed because neighbouring logic decodes it.

Top module: `acc_flag_unit`

## Requirements
- R1: Circular rotates: code 0 rotates the accumulator left, with old bit 7 landing in both bit 0 and C. Code 1 rotates it right, with old bit 0 landing in both bit 7 and C.
- R2: Through-carry rotates: code 2 shifts left, with the old C entering bit 0 and old bit 7 going to C. Code 3 shifts right, with the old C entering bit 7 and old bit 0 going to C.
- R3: The flag byte layout is S=bit 7, Z=6, F5=5, H=4, F3=3, PV=2, N=1, C=0. For codes 0 to 3, H and N are cleared, F5 and F3 copy bits 5 and 3 of the new accumulator, and S, Z and PV pass through.
- R4: Code 4 inverts every accumulator bit, sets H and N, copies new accumulator bits 5 and 3 into F5 and F3, and preserves S, Z, PV and C.
- R5: Code 5 forces C=1, H=0 and N=0, copies accumulator bits 5 and 3 into F5 and F3, and leaves the accumulator and S, Z, PV unchanged.
- R6: Code 6 moves the old C into H, inverts C and clears N. F5 and F3 come from the accumulator. The accumulator and S, Z, PV are unchanged.
- R7: Code 7 adds 0x06 when the low digit exceeds 9 or H is set. It adds 0x60 when C is set or the accumulator exceeds 0x99. The sum is taken modulo 256.
- R8: After code 7, C is 1 exactly when 0x60 was applied. H is 1 when the low digit exceeded 9. S and Z follow the result, PV is 1 for an even count of ones in the result, F5 and F3 copy result bits 5 and 3, and N is preserved.
- R9: Code 8 sets C from the carry out of the word's top bit and H from the carry out of bit 11. It clears N and copies sum bits 13 and 11 into F5 and F3. S, Z and PV and the accumulator are preserved.
- R10: The sum output equals the word sum of both operands, modulo 2^16, for every code. Codes 9 to 15 leave the accumulator and the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (0 to 8 defined) |
| accIn | input | 8 | Current accumulator |
| flagsIn | input | 8 | Current flag byte |
| opA | input | WORD_W | First word operand |
| opB | input | WORD_W | Second word operand |
| accOut | output | 8 | New accumulator |
| flagsOut | output | 8 | New flag byte |
| sumOut | output | WORD_W | Word sum of opA and opB |

## Verification
The accumulator operations and the word sum are evaluated together on every input. When an accumulator code is selected, a fault could let the adder's carry or half-carry leak into C or H, or let adder bits leak into F5 and F3. The sweep drives non-trivial word operands alongside every accumulator code and every carry, half-carry and subtract flag combination. It compares accumulator, flag byte and sum at once against an arithmetic model, so any bleed between the two paths shows up as a wrong flag bit.

// File: rtl/afu_pkg.sv
package afu_pkg;

  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_F3 = 3;
  localparam int FL_H  = 4;
  localparam int FL_F5 = 5;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_CPL  = 4'd4,
    OP_SCF  = 4'd5,
    OP_CCF  = 4'd6,
    OP_DAA  = 4'd7,
    OP_ADDW = 4'd8
  } afu_op_e;

  typedef enum logic [1:0] {ACC_KEEP, ACC_ROT, ACC_CPL, ACC_DAA} acc_src_e;
  typedef enum logic [2:0] {C_KEEP, C_SHIFT, C_ONE, C_INV, C_DAA, C_WIDE} c_src_e;
  typedef enum logic [2:0] {H_KEEP, H_ZERO, H_ONE, H_OLDC, H_DAA, H_WIDE} h_src_e;
  typedef enum logic [1:0] {N_KEEP, N_ZERO, N_ONE} n_src_e;
  typedef enum logic [1:0] {XY_KEEP, XY_ACC, XY_WIDE} xy_src_e;

  typedef struct packed {
    acc_src_e accSrc;
    logic     rotRight;
    logic     rotThru;
    c_src_e   cSrc;
    h_src_e   hSrc;
    n_src_e   nSrc;
    xy_src_e  xySrc;
    logic     szpWrite;
  } afu_strobe_t;

endpackage

// File: rtl/afu_ctrl.sv
module afu_ctrl
  import afu_pkg::*;
(
  input  logic [3:0]  opSel,
  output afu_strobe_t strb
);

  always_comb begin
    strb = '{accSrc: ACC_KEEP, rotRight: 1'b0, rotThru: 1'b0, cSrc: C_KEEP,
             hSrc: H_KEEP, nSrc: N_KEEP, xySrc: XY_KEEP, szpWrite: 1'b0};
    case (opSel)
      OP_RLC, OP_RRC, OP_RL, OP_RR: begin
        strb.accSrc   = ACC_ROT;
        strb.rotRight = opSel[0];
        strb.rotThru  = opSel[1];
        strb.cSrc     = C_SHIFT;
        strb.hSrc     = H_ZERO;
        strb.nSrc     = N_ZERO;
        strb.xySrc    = XY_ACC;
      end
      OP_CPL: begin
        strb.accSrc = ACC_CPL;
        strb.hSrc   = H_ONE;
        strb.nSrc   = N_ONE;
        strb.xySrc  = XY_ACC;
      end
      OP_SCF: begin
        strb.cSrc  = C_ONE;
        strb.hSrc  = H_ZERO;
        strb.nSrc  = N_ZERO;
        strb.xySrc = XY_ACC;
      end
      OP_CCF: begin
        strb.cSrc  = C_INV;
        strb.hSrc  = H_OLDC;
        strb.nSrc  = N_ZERO;
        strb.xySrc = XY_ACC;
      end
      OP_DAA: begin
        strb.accSrc   = ACC_DAA;
        strb.cSrc     = C_DAA;
        strb.hSrc     = H_DAA;
        strb.xySrc    = XY_ACC;
        strb.szpWrite = 1'b1;
      end
      OP_ADDW: begin
        strb.cSrc  = C_WIDE;
        strb.hSrc  = H_WIDE;
        strb.nSrc  = N_ZERO;
        strb.xySrc = XY_WIDE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/afu_dpath.sv
module afu_dpath
  import afu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  afu_strobe_t       strb,
  input  logic [7:0]        accIn,
  input  logic [7:0]        flagsIn,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [7:0]        accOut,
  output logic [7:0]        flagsOut,
  output logic [WORD_W-1:0] sumOut
);

  localparam int HC_BIT = WORD_W - 5;
  localparam int F5_BIT = WORD_W - 3;
  localparam int F3_BIT = WORD_W - 5;

  logic [WORD_W:0] wideFull;
  logic [HC_BIT+1:0] wideLow;
  logic wideC, wideH;

  assign wideFull = {1'b0, opA} + {1'b0, opB};
  assign wideLow  = {1'b0, opA[HC_BIT:0]} + {1'b0, opB[HC_BIT:0]};
  assign wideC    = wideFull[WORD_W];
  assign wideH    = wideLow[HC_BIT+1];
  assign sumOut   = wideFull[WORD_W-1:0];

  logic oldC, oldH;
  assign oldC = flagsIn[FL_C];
  assign oldH = flagsIn[FL_H];

  logic [7:0] rotRes;
  logic rotOut, rotIn;

  always_comb begin
    if (strb.rotRight) begin
      rotOut = accIn[0];
      rotIn  = strb.rotThru ? oldC : accIn[0];
      rotRes = {rotIn, accIn[7:1]};
    end else begin
      rotOut = accIn[7];
      rotIn  = strb.rotThru ? oldC : accIn[7];
      rotRes = {accIn[6:0], rotIn};
    end
  end

  logic lowBig, lowFix, highFix;
  logic [7:0] daaCorr, daaRes;

  assign lowBig  = accIn[3:0] > 4'd9;
  assign lowFix  = lowBig | oldH;
  assign highFix = (accIn > 8'h99) | oldC;
  assign daaCorr = {1'b0, highFix, highFix, 1'b0, 1'b0, lowFix, lowFix, 1'b0};
  assign daaRes  = accIn + daaCorr;

  logic [7:0] newAcc;

  always_comb begin
    case (strb.accSrc)
      ACC_ROT: newAcc = rotRes;
      ACC_CPL: newAcc = ~accIn;
      ACC_DAA: newAcc = daaRes;
      default: newAcc = accIn;
    endcase
  end

  assign accOut = newAcc;

  always_comb begin
    flagsOut = flagsIn;
    case (strb.cSrc)
      C_SHIFT: flagsOut[FL_C] = rotOut;
      C_ONE:   flagsOut[FL_C] = 1'b1;
      C_INV:   flagsOut[FL_C] = ~oldC;
      C_DAA:   flagsOut[FL_C] = highFix;
      C_WIDE:  flagsOut[FL_C] = wideC;
      default: ;
    endcase
    case (strb.hSrc)
      H_ZERO:  flagsOut[FL_H] = 1'b0;
      H_ONE:   flagsOut[FL_H] = 1'b1;
      H_OLDC:  flagsOut[FL_H] = oldC;
      H_DAA:   flagsOut[FL_H] = lowBig;
      H_WIDE:  flagsOut[FL_H] = wideH;
      default: ;
    endcase
    case (strb.nSrc)
      N_ZERO:  flagsOut[FL_N] = 1'b0;
      N_ONE:   flagsOut[FL_N] = 1'b1;
      default: ;
    endcase
    case (strb.xySrc)
      XY_ACC: begin
        flagsOut[FL_F5] = newAcc[5];
        flagsOut[FL_F3] = newAcc[3];
      end
      XY_WIDE: begin
        flagsOut[FL_F5] = wideFull[F5_BIT];
        flagsOut[FL_F3] = wideFull[F3_BIT];
      end
      default: ;
    endcase
    if (strb.szpWrite) begin
      flagsOut[FL_S]  = newAcc[7];
      flagsOut[FL_Z]  = (newAcc == 8'h00);
      flagsOut[FL_PV] = ~^newAcc;
    end
  end

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import afu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [3:0]        opSel,
  input  logic [7:0]        accIn,
  input  logic [7:0]        flagsIn,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [7:0]        accOut,
  output logic [7:0]        flagsOut,
  output logic [WORD_W-1:0] sumOut
);

  afu_strobe_t strb;

  afu_ctrl i_ctrl (
    .opSel(opSel),
    .strb (strb)
  );

  afu_dpath #(.WORD_W(WORD_W)) i_dpath (
    .strb    (strb),
    .accIn   (accIn),
    .flagsIn (flagsIn),
    .opA     (opA),
    .opB     (opB),
    .accOut  (accOut),
    .flagsOut(flagsOut),
    .sumOut  (sumOut)
  );

endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
  parameter int WORD_W = 16
) (
  input logic [3:0]        opSel,
  input logic [7:0]        accIn,
  input logic [7:0]        flagsIn,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic [7:0]        accOut,
  input logic [7:0]        flagsOut,
  input logic [WORD_W-1:0] sumOut
);

  logic [WORD_W-1:0] refSum;
  assign refSum = opA + opB;

  always_comb begin
    // R1
    rlc_result_chk: assert (opSel != 4'd0 ||
      (accOut == {accIn[6:0], accIn[7]} && flagsOut[0] == accIn[7]));
    // R2
    rr_result_chk: assert (opSel != 4'd3 ||
      (accOut == {flagsIn[0], accIn[7:1]} && flagsOut[0] == accIn[0]));
    // R3
    rot_flags_chk: assert (opSel > 4'd3 ||
      (flagsOut[4] == 1'b0 && flagsOut[1] == 1'b0 &&
       flagsOut[7:6] == flagsIn[7:6] && flagsOut[2] == flagsIn[2]));
    // R4
    cpl_chk: assert (opSel != 4'd4 ||
      (accOut == ~accIn && flagsOut[4] && flagsOut[1] && flagsOut[0] == flagsIn[0]));
    // R5
    scf_chk: assert (opSel != 4'd5 ||
      (flagsOut[0] && !flagsOut[4] && !flagsOut[1]));
    // R6
    ccf_chk: assert (opSel != 4'd6 ||
      (flagsOut[4] == flagsIn[0] && flagsOut[0] == !flagsIn[0] && !flagsOut[1]));
    // R8
    daa_szp_chk: assert (opSel != 4'd7 ||
      (flagsOut[2] == ~^accOut && flagsOut[6] == (accOut == 8'h00) &&
       flagsOut[7] == accOut[7]));
    // R9
    addw_keep_chk: assert (opSel != 4'd8 ||
      (accOut == accIn && flagsOut[7:6] == flagsIn[7:6] &&
       flagsOut[2] == flagsIn[2] && !flagsOut[1]));
    // R10
    sum_always_chk: assert (sumOut == refSum);
    // R10
    undef_pass_chk: assert (opSel < 4'd9 ||
      (accOut == accIn && flagsOut == flagsIn));
  end

endmodule

bind acc_flag_unit afu_checker #(.WORD_W(WORD_W)) i_afu_checker (
  .opSel   (opSel),
  .accIn   (accIn),
  .flagsIn (flagsIn),
  .opA     (opA),
  .opB     (opB),
  .accOut  (accOut),
  .flagsOut(flagsOut),
  .sumOut  (sumOut)
);

// File: tb/test_acc_flag_unit.sv
`timescale 1ns/1ps
module test_acc_flag_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  opSel = '0;
  logic [7:0]  accIn = '0, flagsIn = '0;
  logic [15:0] opA = '0, opB = '0;
  logic [7:0]  accOut, flagsOut;
  logic [15:0] sumOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  acc_flag_unit #(.WORD_W(16)) i_acc_flag_unit (
    .opSel(opSel), .accIn(accIn), .flagsIn(flagsIn), .opA(opA), .opB(opB),
    .accOut(accOut), .flagsOut(flagsOut), .sumOut(sumOut)
  );

  function automatic int setb(int v, int pos, int b);
    return (v & ~(1 << pos)) | ((b & 1) << pos);
  endfunction

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  // returns {acc, flags, sum}
  function automatic logic [31:0] model(int op, int a, int f, int x, int y);
    int c = f & 1;
    int h = (f >> 4) & 1;
    int r = a;
    int nf = f;
    int s = (x + y) % 65536;
    int lo, add, hiFix;
    case (op)
      0: begin r = ((a * 2) + (a / 128)) % 256; nf = setb(nf, 0, a / 128); end
      1: begin r = (a / 2) + 128 * (a % 2);     nf = setb(nf, 0, a % 2); end
      2: begin r = ((a * 2) % 256) + c;         nf = setb(nf, 0, a / 128); end
      3: begin r = (a / 2) + 128 * c;           nf = setb(nf, 0, a % 2); end
      4: begin r = 255 - a; nf = setb(nf, 4, 1); nf = setb(nf, 1, 1); end
      5: begin nf = setb(nf, 0, 1); nf = setb(nf, 4, 0); nf = setb(nf, 1, 0); end
      6: begin nf = setb(nf, 4, c); nf = setb(nf, 0, 1 - c); nf = setb(nf, 1, 0); end
      7: begin
        lo = a % 16;
        add = 0;
        if (lo > 9 || h == 1) add += 6;
        hiFix = (a > 153 || c == 1) ? 1 : 0;
        if (hiFix == 1) add += 96;
        r = (a + add) % 256;
        nf = setb(nf, 4, (lo > 9) ? 1 : 0);
        nf = setb(nf, 0, hiFix);
        nf = setb(nf, 7, r / 128);
        nf = setb(nf, 6, (r == 0) ? 1 : 0);
        nf = setb(nf, 2, (ones(r) % 2 == 0) ? 1 : 0);
      end
      8: begin
        nf = setb(nf, 0, (x + y) / 65536);
        nf = setb(nf, 4, ((x % 4096) + (y % 4096)) / 4096);
        nf = setb(nf, 1, 0);
        nf = setb(nf, 5, (s >> 13) & 1);
        nf = setb(nf, 3, (s >> 11) & 1);
      end
      default: ;
    endcase
    if (op <= 7) begin
      if (op <= 3) begin nf = setb(nf, 4, 0); nf = setb(nf, 1, 0); end
      nf = setb(nf, 5, (r >> 5) & 1);
      nf = setb(nf, 3, (r >> 3) & 1);
    end
    return {8'(r), 8'(nf), 16'(s)};
  endfunction

  function automatic string tagOf(int op);
    case (op)
      0, 1:    return "R1+R3";
      2, 3:    return "R2+R3";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      7:       return "R7+R8";
      8:       return "R9+R10";
      default: return "R10";
    endcase
  endfunction

  task automatic runVec(int op, int a, int f, int x, int y, string tag);
    logic [31:0] exp, got;
    @(negedge clk);
    opSel = 4'(op); accIn = 8'(a); flagsIn = 8'(f); opA = 16'(x); opB = 16'(y);
    @(posedge clk);
    #1;
    exp = model(op, a, f, x, y);
    got = {accOut, flagsOut, sumOut};
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s op=%0d a=%h f=%h x=%h y=%h got=%h expected=%h",
               tag, op, a, f, x, y, got, exp);
    end
  endtask

  function automatic int flagPat(int k);
    return (k & 1) | (((k >> 1) & 1) << 4) | (((k >> 2) & 1) << 1) | ((k * 37) & 8'hEC);
  endfunction

  function automatic int wordPat(int k);
    return (k * 16'h0FF1 + (k << 9) + (k % 3) * 16'h7000) % 65536;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    nChecks++;
    if (accOut !== 8'h00 || flagsOut !== 8'h00 || sumOut !== 16'h0000) begin
      nFails++;
      $display("FAIL R10 reset-state got=%h expected=%h",
               {accOut, flagsOut, sumOut}, 32'h0);
    end
    rstN = 1'b1;

    // Accumulator codes, every accumulator value, carry/half/subtract combinations,
    // with live word operands to expose bleed from the adder.
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 8; k++)
          runVec(op, a, flagPat(k), wordPat(a + k), wordPat(a * 7 + k + 1), tagOf(op));

    // Word add sweep
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        runVec(8, i * 3, (i + j) % 2 == 1 ? 8'hFF : 8'h00, wordPat(i), wordPat(j * 5 + 1), "R9+R10");

    // Word add boundaries
    runVec(8, 8'h12, 8'h00, 16'hFFFF, 16'h0001, "R9 wrap-carry");
    runVec(8, 8'h34, 8'hFF, 16'h0800, 16'h0800, "R9 half-carry");
    runVec(8, 8'h00, 8'h00, 16'h2000, 16'h0800, "R9 f5f3");
    runVec(8, 8'hA5, 8'hC4, 16'h0FFF, 16'h0000, "R9 no-carry");

    // Decimal adjust corners
    runVec(7, 8'h9A, 8'h00, 0, 0, "R7 9A");
    runVec(7, 8'h99, 8'h00, 0, 0, "R7 99");
    runVec(7, 8'h00, 8'h11, 0, 0, "R8 zero-with-HC");
    runVec(7, 8'h15, 8'h10, 0, 0, "R8 H-only");

    // Undefined codes leave accumulator and flags alone
    for (int op = 9; op < 16; op++)
      for (int k = 0; k < 16; k++)
        runVec(op, k * 17, flagPat(k) ^ 8'h5A, wordPat(k), wordPat(k + 9), "R10");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule